// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is an 18-bit first-in-first-out buffer. Its producer and its consumer run on two unrelated clocks. Each side's position pointer is converted to Gray code and passed through a flop synchronizer to the other side. The full, empty and level flags are then computed locally from those synchronized pointers.

The write side is a valid/ready stream. A word enters on a `wclk` edge where `wr_valid` and `wr_ready` are both high and `cfg_load` is low. While `wr_ready` is low the producer must hold its word. A `wr_valid` seen in that state stores nothing.

The read side has two output modes, picked while master reset is held:

- **Standard mode.** `rd_valid` means "not empty". A `rd_ready` pulse seen with `rd_valid` high moves the next word onto `rd_data` at that `rclk` edge.
- **Fall-through mode.** `rd_valid` means a word is already sitting on `rd_data`. A `rd_ready` seen with `rd_valid` consumes that word, and the following word (if any) replaces it at the same edge.

Beyond the data path, the block has:

- Two programmable thresholds, one for almost-empty and one for almost-full. They load either in parallel from the write bus or serially one bit per clock.
- A partial reset, which keeps the thresholds.
- A replay input, which rewinds reading to the first word stored since reset.
- An output-enable gate on the read data.

Top module: `xclk_fifo`

## Requirements
- R1: A write transfer stores `wr_data` when `wr_valid` and `wr_ready` are high and `cfg_load` is low. `wr_ready` is low exactly while DEPTH words are held. A `wr_valid` seen while `wr_ready` is low stores nothing, and the held words read back intact and in order.
- R2: Standard mode: `rd_valid` is high whenever the FIFO is not empty. A `rd_ready` seen at an `rclk` edge with `rd_valid` high puts the oldest word on `rd_data` after that edge. Words leave in write order.
- R3: Fall-through mode: the first word written to an empty FIFO appears on `rd_data` with `rd_valid` high and no read request. A `rd_ready` seen with `rd_valid` high replaces it with the next word, or drops `rd_valid` when no word remains.
- R4: While `mrst_n` is low, `ser_in` selects the read mode: 0 gives standard, 1 gives fall-through. The mode holds until the next master reset. In standard mode `rd_data` does not change without a read.
- R5: `half_full` is high when more than DEPTH/2 words are held.
- R6: `almost_full` is high when the free space (DEPTH minus words held) is at or below the almost-full threshold.
- R7: `almost_empty` is high when the words held (in fall-through mode, including the word on `rd_data`) are at or below the almost-empty threshold.
- R8: Master reset empties the FIFO and sets both thresholds to a preset. `preset_sel` low while `mrst_n` is low gives PRE_LO (default 2). `preset_sel` high gives PRE_HI (default 5). After reset: `rd_valid` is 0, `wr_ready` is 1, `half_full` is 0, `almost_full` is 0 and `almost_empty` is 1.
- R9: Partial reset (`prst_n` low) empties the FIFO but leaves both thresholds as they were programmed.
- R10: A write handshake with `cfg_load` high stores no word. Instead it loads `wr_data[AW-1:0]` into a threshold. The first such load after a reset goes to almost-empty, the next to almost-full, and so on alternately.
- R11: With `cfg_load` and `ser_en` high, each `wclk` edge shifts `ser_in` into the threshold pair. Bits go in almost-empty MSB first, then almost-full MSB first, over 2*AW clocks. No word is stored.
- R12: `replay` high at an `rclk` edge rewinds reading to the first word stored since the last reset. A read request in the same cycle is ignored: `rd_data` holds and no word is consumed. The following reads return the stored words again from the first.
- R13: With `rd_oe` low, `rd_data` is all zeros. With `rd_oe` high it shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low; keeps thresholds |
| wr_valid | input | 1 | Producer offers a word (or a threshold value with `cfg_load`) |
| wr_ready | output | 1 | FIFO can accept a word (not full) |
| wr_data | input | DW | Write data; low AW bits also carry parallel threshold values |
| cfg_load | input | 1 | Steers write handshakes and serial bits into the thresholds |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_in | input | 1 | Serial threshold bit; read-mode select during master reset |
| preset_sel | input | 1 | Threshold preset choice, sampled during master reset |
| rd_ready | input | 1 | Consumer read request |
| rd_valid | output | 1 | Standard: not empty; fall-through: word present on `rd_data` |
| rd_data | output | DW | Read data, gated by `rd_oe` |
| rd_oe | input | 1 | Output enable for `rd_data` |
| replay | input | 1 | Rewind reading to the first stored word |
| half_full | output | 1 | More than DEPTH/2 words held (write clock) |
| almost_full | output | 1 | Free space at or below almost-full threshold (write clock) |
| almost_empty | output | 1 | Occupancy at or below almost-empty threshold (read clock) |

## Verification
Replay and an ordinary read request can land in the same read-clock cycle. This is the collision the bench provokes on purpose: after two words have been read, it raises `rd_ready` and `replay` together for one cycle. It then judges the outcome in two steps. First, `rd_data` must still show the second word, which proves the read was dropped. Second, the next four reads must return the stored words from the first one onward, with nothing skipped and nothing duplicated.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;
  // Read-side output behaviour, latched from ser_in during master reset
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/xclk_fifo_sync.sv
module xclk_fifo_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/xclk_fifo_ofs.sv
module xclk_fifo_ofs #(
  parameter int AW     = 4,
  parameter int PRE_LO = 2,
  parameter int PRE_HI = 5
) (
  input  logic          wclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          preset_sel,
  input  logic          cfg_load,
  input  logic          wr_valid,
  input  logic [AW-1:0] par_d,
  input  logic          ser_en,
  input  logic          ser_in,
  output logic [AW-1:0] ae_off,
  output logic [AW-1:0] af_off
);
  localparam logic [AW-1:0] LO = AW'(PRE_LO);
  localparam logic [AW-1:0] HI = AW'(PRE_HI);

  logic pick_af;  // next parallel load targets almost-full

  always_ff @(posedge wclk) begin
    if (!mrst_n) begin
      ae_off  <= preset_sel ? HI : LO;
      af_off  <= preset_sel ? HI : LO;
      pick_af <= 1'b0;
    end else if (!prst_n) begin
      pick_af <= 1'b0;
    end else if (cfg_load && wr_valid) begin
      if (pick_af) af_off <= par_d;
      else         ae_off <= par_d;
      pick_af <= ~pick_af;
    end else if (cfg_load && ser_en) begin
      {ae_off, af_off} <= {ae_off[AW-2:0], af_off, ser_in};
    end
  end
endmodule

// File: rtl/xclk_fifo_wctl.sv
module xclk_fifo_wctl #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW:0]   rgray_s,
  input  logic [AW-1:0] af_off,
  output logic          push,
  output logic [AW:0]   wbin,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          half_full,
  output logic          almost_full
);
  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_W  = (AW+1)'(DEPTH / 2);

  logic [AW:0] rbin_s, wbin_nxt, occ, free;

  genvar gi;
  generate
    for (gi = 0; gi <= AW; gi++) begin : g_g2b
      assign rbin_s[gi] = ^rgray_s[AW:gi];
    end
  endgenerate

  assign full     = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
  assign push     = wr_en & ~full;
  assign wbin_nxt = wbin + {{AW{1'b0}}, push};

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  assign occ         = wbin - rbin_s;
  assign free        = DEPTH_W - occ;
  assign half_full   = occ > HALF_W;
  assign almost_full = free <= {1'b0, af_off};
endmodule

// File: rtl/xclk_fifo_rctl.sv
module xclk_fifo_rctl #(
  parameter int DW = 18,
  parameter int AW = 4
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic          replay,
  input  logic [AW:0]   wgray_s,
  input  logic [AW-1:0] ae_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] q,
  output logic          rd_valid,
  output logic          almost_empty
);
  logic [AW:0] wbin_s, rbin_nxt, occ;
  logic        ovalid, ovalid_nxt, mem_empty, load;

  genvar gi;
  generate
    for (gi = 0; gi <= AW; gi++) begin : g_g2b
      assign wbin_s[gi] = ^wgray_s[AW:gi];
    end
  endgenerate

  assign mem_empty = (rbin == wbin_s);
  assign load      = fwft ? (~mem_empty & (~ovalid | rd_en))
                          : (rd_en & ~mem_empty);

  always_comb begin
    rbin_nxt   = rbin;
    ovalid_nxt = ovalid;
    if (replay) begin
      rbin_nxt   = '0;
      ovalid_nxt = 1'b0;
    end else if (load) begin
      rbin_nxt   = rbin + 1'b1;
      ovalid_nxt = 1'b1;
    end else if (rd_en) begin
      ovalid_nxt = 1'b0;
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      ovalid <= 1'b0;
      q      <= '0;
    end else begin
      rbin   <= rbin_nxt;
      rgray  <= rbin_nxt ^ (rbin_nxt >> 1);
      ovalid <= ovalid_nxt;
      if (!replay && load) q <= mem_q;
    end
  end

  assign rd_valid     = fwft ? ovalid : ~mem_empty;
  assign occ          = wbin_s - rbin + {{AW{1'b0}}, fwft & ovalid};
  assign almost_empty = occ <= {1'b0, ae_off};
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo
  import xclk_fifo_pkg::*;
#(
  parameter int DW          = 18,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_LO      = 2,
  parameter int PRE_HI      = 5
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  input  logic          cfg_load,
  input  logic          ser_en,
  input  logic          ser_in,
  input  logic          preset_sel,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_oe,
  input  logic          replay,
  output logic          half_full,
  output logic          almost_full,
  output logic          almost_empty
);
  localparam int AW = $clog2(DEPTH);

  logic          ptr_rst_n;
  logic [AW:0]   wbin, wgray, rbin, rgray, rgray_w, wgray_r;
  logic [AW-1:0] ae_off, af_off;
  logic          push, full, rd_fwft;
  logic [DW-1:0] mem_q, q;
  rd_mode_e      rmode;
  logic [DW-1:0] mem [DEPTH];

  assign ptr_rst_n = mrst_n & prst_n;

  always_ff @(posedge rclk) begin
    if (!mrst_n) rmode <= rd_mode_e'(ser_in);
  end
  assign rd_fwft = (rmode == MODE_FWFT);

  always_ff @(posedge wclk) begin
    if (push) mem[wbin[AW-1:0]] <= wr_data;
  end
  assign mem_q = mem[rbin[AW-1:0]];

  xclk_fifo_ofs #(.AW(AW), .PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_ofs (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .preset_sel(preset_sel),
    .cfg_load(cfg_load), .wr_valid(wr_valid), .par_d(wr_data[AW-1:0]),
    .ser_en(ser_en), .ser_in(ser_in), .ae_off(ae_off), .af_off(af_off)
  );

  xclk_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_w)
  );

  xclk_fifo_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_r)
  );

  xclk_fifo_wctl #(.DEPTH(DEPTH), .AW(AW)) u_wctl (
    .wclk(wclk), .rst_n(ptr_rst_n), .wr_en(wr_valid & ~cfg_load),
    .rgray_s(rgray_w), .af_off(af_off), .push(push), .wbin(wbin),
    .wgray(wgray), .full(full), .half_full(half_full),
    .almost_full(almost_full)
  );

  xclk_fifo_rctl #(.DW(DW), .AW(AW)) u_rctl (
    .rclk(rclk), .rst_n(ptr_rst_n), .fwft(rd_fwft), .rd_en(rd_ready),
    .replay(replay), .wgray_s(wgray_r), .ae_off(ae_off), .mem_q(mem_q),
    .rbin(rbin), .rgray(rgray), .q(q), .rd_valid(rd_valid),
    .almost_empty(almost_empty)
  );

  assign wr_ready = ~full;
  assign rd_data  = rd_oe ? q : '0;
endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
  parameter int AW = 4
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrst_n,
  input logic          prst_n,
  input logic          ptr_rst_n,
  input logic          wr_ready,
  input logic          rd_valid,
  input logic          replay,
  input logic          rd_fwft,
  input logic [AW:0]   wbin,
  input logic [AW:0]   wgray,
  input logic [AW:0]   rbin,
  input logic [AW:0]   rgray,
  input logic [AW-1:0] ae_off,
  input logic [AW-1:0] af_off
);
  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!ptr_rst_n)
    !wr_ready |=> $stable(wbin));

  // R1
  wgray_step_chk: assert property (@(posedge wclk) disable iff (!ptr_rst_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!ptr_rst_n)
    (!rd_fwft && !rd_valid && !replay) |=> $stable(rbin));

  // R2
  rgray_step_chk: assert property (@(posedge rclk) disable iff (!ptr_rst_n)
    !$past(replay) |-> ($countones(rgray ^ $past(rgray)) <= 1));

  // R12
  replay_rewind_chk: assert property (@(posedge rclk) disable iff (!ptr_rst_n)
    replay |=> (rbin == '0));

  // R9
  prst_keep_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
    !prst_n |=> ($stable(ae_off) && $stable(af_off)));
endmodule

bind xclk_fifo xclk_fifo_chk #(.AW(AW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
  .ptr_rst_n(ptr_rst_n), .wr_ready(wr_ready), .rd_valid(rd_valid),
  .replay(replay), .rd_fwft(rd_fwft), .wbin(wbin), .wgray(wgray),
  .rbin(rbin), .rgray(rgray), .ae_off(ae_off), .af_off(af_off)
);

// File: tb/xclk_fifo_tb.sv
module xclk_fifo_tb;
  localparam int DW = 18;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic mrst_n = 0, prst_n = 1;
  logic wr_valid = 0, cfg_load = 0, ser_en = 0, ser_in = 0, preset_sel = 0;
  logic rd_ready = 0, rd_oe = 1, replay = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, half_full, almost_full, almost_empty;
  logic [DW-1:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 wclk = ~wclk;  // 250 MHz
  always #3 rclk = ~rclk;

  xclk_fifo #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .cfg_load(cfg_load), .ser_en(ser_en), .ser_in(ser_in),
    .preset_sel(preset_sel), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_oe(rd_oe), .replay(replay),
    .half_full(half_full), .almost_full(almost_full),
    .almost_empty(almost_empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic master_reset(input logic sel, input logic fw);
    @(negedge wclk);
    mrst_n = 0; preset_sel = sel; ser_in = fw;
    wr_valid = 0; cfg_load = 0; ser_en = 0; rd_ready = 0; replay = 0;
    repeat (4) @(negedge rclk);
    @(negedge wclk);
    mrst_n = 1; ser_in = 0;
    settle();
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_valid = 1; wr_data = d;
    @(negedge wclk);
    wr_valid = 0;
  endtask

  task automatic push_n(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) push(base + DW'(i));
  endtask

  task automatic pop(output logic [DW-1:0] d);
    @(negedge rclk);
    rd_ready = 1;
    @(negedge rclk);
    rd_ready = 0;
    d = rd_data;
  endtask

  task automatic t_reset();
    master_reset(0, 0);
    chk("R8 rd_valid after reset", rd_valid, 0);
    chk("R8 wr_ready after reset", wr_ready, 1);
    chk("R8 half_full after reset", half_full, 0);
    chk("R8 almost_full after reset", almost_full, 0);
    chk("R8 almost_empty after reset", almost_empty, 1);
  endtask

  task automatic t_std();
    logic [DW-1:0] d;
    push_n(3, 'h100);
    settle();
    chk("R2 rd_valid with data", rd_valid, 1);
    chk("R4 std mode no fall-through", rd_data, 0);
    chk("R7 almost_empty occ 3", almost_empty, 0);
    pop(d); chk("R2 first word", d, 'h100);
    chk("R7 almost_empty occ 2", almost_empty, 1);
    pop(d); chk("R2 second word", d, 'h101);
    pop(d); chk("R2 third word", d, 'h102);
    settle();
    chk("R2 rd_valid when empty", rd_valid, 0);
  endtask

  task automatic t_fill();
    logic [DW-1:0] d;
    push_n(8, 'h200);
    chk("R5 half_full at DEPTH/2", half_full, 0);
    push('h208);
    chk("R5 half_full above DEPTH/2", half_full, 1);
    push_n(4, 'h209);
    chk("R6 almost_full free 3", almost_full, 0);
    push('h20D);
    chk("R6 almost_full free 2", almost_full, 1);
    push('h20E);
    chk("R1 wr_ready at DEPTH-1", wr_ready, 1);
    push('h20F);
    chk("R1 wr_ready low when full", wr_ready, 0);
    push('h3AA);
    push('h3AB);
    settle();
    for (int i = 0; i < DEPTH; i++) begin
      pop(d);
      chk("R1 stored word intact", d, 'h200 + i);
    end
    settle();
    chk("R1 writes while full dropped", rd_valid, 0);
    chk("R5 half_full cleared", half_full, 0);
  endtask

  task automatic t_preset_hi();
    master_reset(1, 0);
    chk("R8 hi preset empty ae", almost_empty, 1);
    push_n(5, 'h10);
    settle();
    chk("R8 hi preset ae occ 5", almost_empty, 1);
    push('h15);
    settle();
    chk("R8 hi preset ae occ 6", almost_empty, 0);
    push_n(4, 'h16);
    chk("R8 hi preset af free 6", almost_full, 0);
    push('h1A);
    chk("R8 hi preset af free 5", almost_full, 1);
  endtask

  task automatic t_par();
    master_reset(0, 0);
    cfg_load = 1;
    push(3);
    push(1);
    cfg_load = 0;
    settle();
    chk("R10 parallel load stores no word", rd_valid, 0);
    push_n(3, 'h40);
    settle();
    chk("R10 ae threshold 3 occ 3", almost_empty, 1);
    push('h43);
    settle();
    chk("R10 ae threshold 3 occ 4", almost_empty, 0);
    push_n(10, 'h44);
    chk("R10 af threshold 1 free 2", almost_full, 0);
    push('h4E);
    chk("R10 af threshold 1 free 1", almost_full, 1);
  endtask

  task automatic t_prst();
    @(negedge wclk); prst_n = 0;
    repeat (3) @(negedge rclk);
    @(negedge wclk); prst_n = 1;
    settle();
    chk("R9 partial reset empties", rd_valid, 0);
    chk("R9 partial reset wr_ready", wr_ready, 1);
    push_n(3, 'h50);
    settle();
    chk("R9 ae threshold kept occ 3", almost_empty, 1);
    push('h53);
    settle();
    chk("R9 ae threshold kept occ 4", almost_empty, 0);
  endtask

  task automatic t_ser();
    logic [7:0] bits;
    bits = 8'b0110_0011;  // ae = 6, af = 3
    master_reset(0, 0);
    @(negedge wclk);
    cfg_load = 1; ser_en = 1;
    for (int i = 7; i >= 0; i--) begin
      ser_in = bits[i];
      @(negedge wclk);
    end
    cfg_load = 0; ser_en = 0; ser_in = 0;
    settle();
    chk("R11 serial load stores no word", rd_valid, 0);
    push_n(6, 'h60);
    settle();
    chk("R11 ae threshold 6 occ 6", almost_empty, 1);
    push('h66);
    settle();
    chk("R11 ae threshold 6 occ 7", almost_empty, 0);
    push_n(5, 'h67);
    chk("R11 af threshold 3 free 4", almost_full, 0);
    push('h6C);
    chk("R11 af threshold 3 free 3", almost_full, 1);
  endtask

  task automatic t_fwft();
    master_reset(0, 1);
    push('h155);
    settle();
    chk("R4 fall-through rd_valid", rd_valid, 1);
    chk("R3 first word falls through", rd_data, 'h155);
    @(negedge wclk); rd_oe = 0;
    @(negedge wclk);
    chk("R13 rd_oe low gates data", rd_data, 0);
    rd_oe = 1;
    @(negedge wclk);
    chk("R13 rd_oe high shows data", rd_data, 'h155);
    push('h156);
    push('h157);
    settle();
    @(negedge rclk); rd_ready = 1;
    @(negedge rclk); rd_ready = 0;
    chk("R3 next word after consume", rd_data, 'h156);
    @(negedge rclk); rd_ready = 1;
    @(negedge rclk); rd_ready = 0;
    chk("R3 third word after consume", rd_data, 'h157);
    @(negedge rclk); rd_ready = 1;
    @(negedge rclk); rd_ready = 0;
    chk("R3 rd_valid drops when drained", rd_valid, 0);
  endtask

  task automatic t_replay();
    logic [DW-1:0] d;
    master_reset(0, 0);
    push_n(4, 'h300);
    settle();
    pop(d); chk("R12 pre-replay word 0", d, 'h300);
    pop(d); chk("R12 pre-replay word 1", d, 'h301);
    @(negedge rclk); rd_ready = 1; replay = 1;
    @(negedge rclk); rd_ready = 0; replay = 0;
    chk("R12 read ignored during replay", rd_data, 'h301);
    for (int i = 0; i < 4; i++) begin
      pop(d);
      chk("R12 replayed word", d, 'h300 + i);
    end
    settle();
    chk("R12 empty after replayed words", rd_valid, 0);
  endtask

  initial begin
    t_reset();
    t_std();
    t_fill();
    t_preset_hi();
    t_par();
    t_prst();
    t_ser();
    t_fwft();
    t_replay();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule